// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers interrupt causes from a serial peripheral and reports them to a host through one top-level status register and three detail registers. The detail registers cover line conditions, special-character matches and general status. Each status bit has its own enable bit. The block drives one active-low interrupt request, which is low while any enabled top-level bit is set.

The five upper bits of the top-level register hold frequent events that the host can see directly. The three lower bits summarise the detail registers. A summary bit is set when its detail register holds at least one bit whose enable is set. To identify a rarer cause, the host first reads the top-level register and then reads the detail register that the summary bit points to.

Three clearing rules apply:
- The top-level event bits clear when the top-level register is read.
- The special-character and general-status registers also clear when read.
- Line-status bits follow their level inputs and ignore reads.

Top module: `irq_agg`

## Requirements
- R1: After reset, all four status registers and all four enable registers read as zero, and `irq_n_o` is high.
- R2: A write strobe stores `wdata_i` into the enable register at the addressed location. Enable addresses are 1 (top), 3 (line), 5 (special) and 7 (general). The value reads back unchanged.
- R3: A one-cycle pulse on a bit of `spc_ev_i`, `gen_ev_i` or `top_ev_i` sets the matching status bit, and the bit stays set until it is cleared. `top_ev_i[k]` maps to top-level bit k+3. Read data appears on `rdata_o` in the cycle after the read strobe. Status addresses are 0 (top), 2 (line), 4 (special) and 6 (general).
- R4: A read strobe at address 0 clears top-level bits 7..3. A read strobe at address 4 clears the special register, and a read strobe at address 6 clears the general register. In each case the read returns the value held before clearing.
- R5: If an event pulse for a register arrives on the same edge as a clearing read of that register, the read returns the old value and the new event bit stays set afterwards.
- R6: The line-status register copies `line_lvl_i` with one cycle of latency. Reading address 2 does not change it.
- R7: The top-level register's bits 0, 1 and 2 are set exactly when the line, special or general register, respectively, has a set bit whose enable is set. These bits fall once that condition ends.
- R8: `irq_n_o` is low exactly when some top-level bit and its top enable bit are both set. Reading the top-level register with no enabled pending detail cause returns `irq_n_o` high.
- R9: Writes to status addresses 0, 2, 4 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle after the read strobe |
| top_ev_i | input | 5 | Frequent event pulses, mapped to top-level bits 7..3 |
| line_lvl_i | input | 8 | Line condition levels |
| spc_ev_i | input | 8 | Special-character event pulses |
| gen_ev_i | input | 8 | General-status event pulses |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
A sticky bit that is lost or cleared early appears as a zero on the next read of its register, and also as `irq_n_o` rising too soon. Both show within one cycle of the faulty edge. A clear that fails leaves a non-zero second read and keeps `irq_n_o` low. A wrong mask or summary shows in the top-level read value and in the interrupt line on the cycle after the enable write or the event. The same-edge read-and-event case is driven on purpose, because a design where the clear wins passes every other test.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NUM_SUM = 3;

    localparam logic [ADDR_W-1:0] A_TOP_ST  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TOP_EN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LINE_ST = 3'd2;
    localparam logic [ADDR_W-1:0] A_LINE_EN = 3'd3;
    localparam logic [ADDR_W-1:0] A_SPC_ST  = 3'd4;
    localparam logic [ADDR_W-1:0] A_SPC_EN  = 3'd5;
    localparam logic [ADDR_W-1:0] A_GEN_ST  = 3'd6;
    localparam logic [ADDR_W-1:0] A_GEN_EN  = 3'd7;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bits_d, bits_q;

    // A new event beats a clear on the same edge.
    always_comb begin
        bits_d = clr_i ? '0 : bits_q;
        bits_d = bits_d | set_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) bits_q <= '0;
        else       bits_q <= bits_d;
    end

    assign q_o = bits_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3,
    localparam int unsigned N = 1 << AW
) (
    input  logic [N-1:0][DW-1:0] regs_i,
    input  logic [AW-1:0]        sel_i,
    output logic [DW-1:0]        data_o
);
    always_comb data_o = regs_i[sel_i];
endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned EV_W = DATA_W - NUM_SUM
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [EV_W-1:0]   top_ev_i,
    input  logic [DATA_W-1:0] line_lvl_i,
    input  logic [DATA_W-1:0] spc_ev_i,
    input  logic [DATA_W-1:0] gen_ev_i,
    output logic              irq_n_o
);
    localparam int unsigned NREG = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] top_en;
        logic [DATA_W-1:0] line_en;
        logic [DATA_W-1:0] spc_en;
        logic [DATA_W-1:0] gen_en;
        logic [DATA_W-1:0] line_st;
        logic [DATA_W-1:0] rdata;
    } agg_state_t;

    agg_state_t st_d, st_q;

    logic [EV_W-1:0]   top_ev_st;
    logic [DATA_W-1:0] spc_st, gen_st;
    logic [NUM_SUM-1:0] summary;
    logic [DATA_W-1:0] top_view;
    logic [DATA_W-1:0] rd_mux;
    logic [NREG-1:0][DATA_W-1:0] reg_file;
    logic clr_top, clr_spc, clr_gen;

    assign clr_top = rd_en_i && (addr_i == A_TOP_ST);
    assign clr_spc = rd_en_i && (addr_i == A_SPC_ST);
    assign clr_gen = rd_en_i && (addr_i == A_GEN_ST);

    irq_sticky_bank #(.W(EV_W)) u_top_bank (
        .clk_i(clk_i), .rst_i(rst_i), .set_i(top_ev_i), .clr_i(clr_top), .q_o(top_ev_st)
    );
    irq_sticky_bank #(.W(DATA_W)) u_spc_bank (
        .clk_i(clk_i), .rst_i(rst_i), .set_i(spc_ev_i), .clr_i(clr_spc), .q_o(spc_st)
    );
    irq_sticky_bank #(.W(DATA_W)) u_gen_bank (
        .clk_i(clk_i), .rst_i(rst_i), .set_i(gen_ev_i), .clr_i(clr_gen), .q_o(gen_st)
    );

    always_comb begin
        summary[0] = |(st_q.line_st & st_q.line_en);
        summary[1] = |(spc_st & st_q.spc_en);
        summary[2] = |(gen_st & st_q.gen_en);
        top_view   = {top_ev_st, summary};
    end

    always_comb begin
        reg_file[A_TOP_ST]  = top_view;
        reg_file[A_TOP_EN]  = st_q.top_en;
        reg_file[A_LINE_ST] = st_q.line_st;
        reg_file[A_LINE_EN] = st_q.line_en;
        reg_file[A_SPC_ST]  = spc_st;
        reg_file[A_SPC_EN]  = st_q.spc_en;
        reg_file[A_GEN_ST]  = gen_st;
        reg_file[A_GEN_EN]  = st_q.gen_en;
    end

    irq_read_mux #(.DW(DATA_W), .AW(ADDR_W)) u_mux (
        .regs_i(reg_file), .sel_i(addr_i), .data_o(rd_mux)
    );

    always_comb begin
        st_d = st_q;
        st_d.line_st = line_lvl_i;
        if (rd_en_i) st_d.rdata = rd_mux;
        if (wr_en_i) begin
            case (addr_i)
                A_TOP_EN:  st_d.top_en  = wdata_i;
                A_LINE_EN: st_d.line_en = wdata_i;
                A_SPC_EN:  st_d.spc_en  = wdata_i;
                A_GEN_EN:  st_d.gen_en  = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign irq_n_o = ~|(top_view & st_q.top_en);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [2:0]        addr_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] line_lvl_i,
    input logic [DATA_W-1:0] spc_ev_i,
    input logic [DATA_W-1:0] spc_q,
    input logic [DATA_W-1:0] line_q,
    input logic [DATA_W-1:0] top_en,
    input logic              irq_n_o
);
    // R3
    spc_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rd_en_i && addr_i == 3'd4) |=> ((spc_q & $past(spc_q)) == $past(spc_q)));
    // R4
    spc_cor_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_en_i && addr_i == 3'd4 && spc_ev_i == '0) |=> (spc_q == '0));
    // R5
    event_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (spc_ev_i != '0) |=> ((spc_q & $past(spc_ev_i)) == $past(spc_ev_i)));
    // R6
    line_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (line_q == $past(line_lvl_i)));
    // R8
    masked_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (top_en == '0) |-> irq_n_o);
    // R9
    wr_ignore_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == 3'd4 && !rd_en_i) |=> (spc_q == ($past(spc_q) | $past(spc_ev_i))));
endmodule

bind irq_agg irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .addr_i(addr_i), .rd_en_i(rd_en_i), .wr_en_i(wr_en_i),
    .line_lvl_i(line_lvl_i), .spc_ev_i(spc_ev_i), .spc_q(spc_st), .line_q(st_q.line_st),
    .top_en(st_q.top_en), .irq_n_o(irq_n_o)
);

// File: tb/tb_irq_agg.sv
module tb_irq_agg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [4:0] top_ev = '0;
    logic [7:0] line_lvl = '0, spc_ev = '0, gen_ev = '0;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    logic pend = 1'b0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    irq_agg dut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .wdata_i(wdata), .rdata_o(rdata), .top_ev_i(top_ev), .line_lvl_i(line_lvl),
        .spc_ev_i(spc_ev), .gen_ev_i(gen_ev), .irq_n_o(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) pend <= rd_en;

    // Monitor: compares each read result against the scoreboard.
    initial forever begin
        @(negedge clk);
        if (pend) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (rdata !== e.val) begin
                bad++;
                $display("FAIL %s: rdata=%h expected=%h", e.tag, rdata, e.val);
            end
        end
    end

    task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        sb.push_back('{exp, tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] t, input logic [7:0] s, input logic [7:0] g);
        @(negedge clk);
        top_ev = t; spc_ev = s; gen_ev = g;
        @(negedge clk);
        top_ev = '0; spc_ev = '0; gen_ev = '0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (irq_n !== exp) begin
            bad++;
            $display("FAIL %s: irq_n=%b expected=%b", tag, irq_n, exp);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        bad++; total++;
        $display("FAIL watchdog: timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk_irq(1'b1, "R1");
        for (int i = 0; i < 8; i++) do_read(3'(i), 8'h00, "R1");

        // R2 enable registers
        do_write(3'd3, 8'h0F);
        do_write(3'd5, 8'hFF);
        do_write(3'd7, 8'h01);
        do_read(3'd3, 8'h0F, "R2 line_en");
        do_read(3'd5, 8'hFF, "R2 spc_en");
        do_read(3'd7, 8'h01, "R2 gen_en");
        do_read(3'd1, 8'h00, "R2 top_en");

        // R3 R7 R8 special events, masked at top
        pulse('0, 8'h24, '0);
        chk_irq(1'b1, "R8 masked");
        do_read(3'd0, 8'h02, "R7 spc summary");
        do_read(3'd4, 8'h24, "R3 spc sticky");
        do_read(3'd4, 8'h00, "R4 spc cleared");
        do_read(3'd0, 8'h00, "R7 summary falls");

        // R8 interrupt via summary
        do_write(3'd1, 8'h02);
        pulse('0, 8'h01, '0);
        chk_irq(1'b0, "R8 asserted");
        do_read(3'd4, 8'h01, "R3 spc");
        chk_irq(1'b1, "R8 released");

        // R7 general masked bits, R4 clear
        pulse('0, '0, 8'h06);
        do_read(3'd0, 8'h00, "R7 gen masked");
        do_read(3'd6, 8'h06, "R3 gen sticky");
        do_read(3'd6, 8'h00, "R4 gen cleared");

        // Top-level direct events
        do_write(3'd1, 8'h08);
        pulse(5'b00001, '0, '0);
        chk_irq(1'b0, "R8 top event");
        do_read(3'd0, 8'h08, "R3 top event");
        chk_irq(1'b1, "R8 after top read");
        do_read(3'd0, 8'h00, "R4 top cleared");
        pulse(5'b10000, '0, '0);
        chk_irq(1'b1, "R8 unenabled top bit");
        do_read(3'd0, 8'h80, "R3 top bit7");

        // R6 line status levels
        @(negedge clk); line_lvl = 8'h03;
        do_read(3'd2, 8'h03, "R6 line follows");
        do_read(3'd2, 8'h03, "R6 no clear on read");
        do_read(3'd0, 8'h01, "R7 line summary");
        @(negedge clk); line_lvl = 8'h00;
        do_read(3'd2, 8'h00, "R6 line drops");
        do_read(3'd0, 8'h00, "R7 line summary drops");

        // R5 event during clearing read
        pulse('0, 8'h10, '0);
        @(negedge clk);
        addr = 3'd4; rd_en = 1'b1; spc_ev = 8'h80;
        sb.push_back('{8'h10, "R5 old value"});
        @(negedge clk);
        rd_en = 1'b0; spc_ev = '0;
        do_read(3'd4, 8'h80, "R5 new event kept");
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1; top_ev = 5'b00010;
        sb.push_back('{8'h00, "R5 top old"});
        @(negedge clk);
        rd_en = 1'b0; top_ev = '0;
        do_read(3'd0, 8'h10, "R5 top new kept");

        // R9 writes to status addresses ignored
        do_write(3'd4, 8'hFF);
        do_write(3'd0, 8'hFF);
        do_write(3'd6, 8'hFF);
        do_read(3'd4, 8'h00, "R9 spc");
        do_read(3'd0, 8'h00, "R9 top");
        do_read(3'd6, 8'h00, "R9 gen");

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule